// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block is a 16-bit down-counting timer that software drives through three memory-mapped registers: a control/status word, a modulus word and a read-only view of the live count. The count steps down at the system clock halved and then divided by a power of two that software picks, from 1 to 32768. When the count expires it restarts from the modulus value (reload mode) or from 0xFFFF (free-running mode). On every expiry it sets an interrupt flag, which drives a level interrupt output when the interrupt enable bit is also set.

Software clears the flag by writing a one to its bit or by writing the modulus register. An overwrite bit lets a modulus write load the counter at once, not at the next reload. A control write that touches only the interrupt enable or the flag leaves the running count and the prescaler phase alone. Any other control change restarts the prescaler and reloads the counter from the current limit on the first prescaled tick.

Top module: `pit_timer`

## Requirements
- R1: After reset the control, modulus and count registers all read 0, and the interrupt output is 0.
- R2: Byte offset 0 selects control, offset 2 the modulus and offset 4 the count. A read returns its data one cycle after the read strobe. Writes to offset 4 leave the count unchanged.
- R3: Control bits 11:8 hold the prescaler select P. While enabled, the count changes once every 2*2^P clock cycles. The first change comes 2*2^P cycles after the restarting control write.
- R4: With control bit 1 (reload) set, a tick taken while the count is 0 loads the modulus value. The modulus is read at the moment of the reload.
- R5: With reload clear, a tick taken while the count is 0 loads 0xFFFF.
- R6: Control bit 2 is the interrupt flag. It sets on the tick that finds the count at 0. A control write with bit 2 = 1 clears it, and one with bit 2 = 0 leaves it as it is.
- R7: The interrupt output equals flag AND control bit 3 (interrupt enable), and it updates in the same cycle as either of them.
- R8: Any write to the modulus register clears the interrupt flag.
- R9: With control bit 4 (overwrite) set, a modulus write loads the counter in the same cycle. With it clear, the counter keeps counting and uses the new value only at the next reload.
- R10: A control write that differs from the stored value only in bits 3 and 2 leaves the count and the tick timing undisturbed.
- R11: While control bit 0 (enable) is 0, the count holds its value.
- R12: A control write that changes any bit other than 3 or 2 restarts the prescaler. The next tick then loads the current limit (modulus or 0xFFFF) without setting the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data, valid the cycle after bus_re |
| irq | output | 1 | Level interrupt request |

## Verification
The bench places every read at an exact cycle distance from the restarting write. A prescaler that is off by one stage, or a first load that comes one tick early, therefore shows up as a wrong count value. It follows a full reload period through expiry to check that the flag and the interrupt rise together with the reload. A design that set the flag on the first-load tick, or that reloaded 0xFFFF in reload mode, would miscompare there. Modulus writes are made both with and without overwrite. An immediate load where none belongs, or a stale limit at the next reload, then gives a wrong count. Control writes that change only the interrupt bits, writes of zero to the flag, and writes to the count register are each followed by a read of the count or the flag. A design that restarted on those writes, cleared the flag on a zero, or let the count be written would fail those reads.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int CNT_W  = 16;
  localparam int PRE_W  = 4;
  localparam int ADDR_W = 3;

  localparam int B_EN   = 0;
  localparam int B_RLD  = 1;
  localparam int B_FLAG = 2;
  localparam int B_PIE  = 3;
  localparam int B_OVW  = 4;
  localparam int B_PRE  = 8;

  localparam logic [15:0] CTRL_STORE   = 16'h0F7B;
  localparam logic [15:0] CTRL_RESTART = 16'h0F73;

  typedef enum logic [ADDR_W-1:0] {
    OFS_CTRL = 3'd0,
    OFS_MOD  = 3'd2,
    OFS_CNT  = 3'd4
  } pit_ofs_e;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int PRE_W = 4,
  localparam int DIV_W = (1 << PRE_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clear,
  input  logic [PRE_W-1:0] sel,
  output logic             tick
);
  logic             half_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      mask[i] = (i < int'(sel));
    end
  end

  assign tick = run && !clear && half_q && (div_q == mask);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      half_q <= 1'b0;
      div_q  <= '0;
    end else if (run) begin
      half_q <= ~half_q;
      if (half_q) begin
        div_q <= (div_q == mask) ? '0 : div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic             force_ld,
  input  logic [CNT_W-1:0] force_val,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             pending,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;

  assign expire  = tick && !pend_q && (cnt_q == '0);
  assign count   = cnt_q;
  assign pending = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pend_q <= 1'b1;
    end else if (restart) begin
      pend_q <= 1'b1;
    end else if (force_ld) begin
      cnt_q  <= force_val;
      pend_q <= 1'b0;
    end else if (tick) begin
      pend_q <= 1'b0;
      if (pend_q || cnt_q == '0) begin
        cnt_q <= limit;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              expire,
  input  logic [CNT_W-1:0]  count,
  output logic [15:0]       bus_rdata,
  output logic              irq,
  output logic              en,
  output logic              rld,
  output logic              pie,
  output logic              ovw,
  output logic [PRE_W-1:0]  pre,
  output logic [CNT_W-1:0]  modulus,
  output logic              flag,
  output logic              restart,
  output logic              force_ld
);
  logic [15:0]      ctrl_q;
  logic [CNT_W-1:0] mod_q;
  logic             flag_q;
  logic             wr_ctrl, wr_mod;
  logic             flag_nxt;
  logic [15:0]      ctrl_nxt;
  logic [15:0]      ctrl_view;
  logic [15:0]      rd_mux;

  assign wr_ctrl  = bus_we && (bus_addr == OFS_CTRL);
  assign wr_mod   = bus_we && (bus_addr == OFS_MOD);
  assign restart  = wr_ctrl && (((ctrl_q ^ bus_wdata) & CTRL_RESTART) != '0);
  assign force_ld = wr_mod && ctrl_q[B_OVW];
  assign ctrl_nxt = wr_ctrl ? (bus_wdata & CTRL_STORE) : ctrl_q;

  always_comb begin
    if (expire) begin
      flag_nxt = 1'b1;
    end else if ((wr_ctrl && bus_wdata[B_FLAG]) || wr_mod) begin
      flag_nxt = 1'b0;
    end else begin
      flag_nxt = flag_q;
    end
  end

  assign ctrl_view = ctrl_q | (16'(flag_q) << B_FLAG);

  always_comb begin
    case (bus_addr)
      OFS_CTRL: rd_mux = ctrl_view;
      OFS_MOD:  rd_mux = 16'(mod_q);
      OFS_CNT:  rd_mux = 16'(count);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      mod_q     <= '0;
      flag_q    <= 1'b0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      ctrl_q <= ctrl_nxt;
      flag_q <= flag_nxt;
      irq    <= flag_nxt && ctrl_nxt[B_PIE];
      if (wr_mod) begin
        mod_q <= bus_wdata[CNT_W-1:0];
      end
      if (bus_re) begin
        bus_rdata <= rd_mux;
      end
    end
  end

  assign en      = ctrl_q[B_EN];
  assign rld     = ctrl_q[B_RLD];
  assign pie     = ctrl_q[B_PIE];
  assign ovw     = ctrl_q[B_OVW];
  assign pre     = ctrl_q[B_PRE +: PRE_W];
  assign modulus = mod_q;
  assign flag    = flag_q;
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int PW = PRE_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic          irq
);
  logic          en, rld, pie, ovw, flag;
  logic [PW-1:0] pre;
  logic [CW-1:0] modulus, count, limit;
  logic          restart, force_ld, tick, expire, pending;

  assign limit = rld ? modulus : '1;

  pit_regs #(.CNT_W(CW), .PRE_W(PW), .ADDR_W(AW)) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .expire(expire),
    .count(count), .bus_rdata(bus_rdata), .irq(irq), .en(en),
    .rld(rld), .pie(pie), .ovw(ovw), .pre(pre), .modulus(modulus),
    .flag(flag), .restart(restart), .force_ld(force_ld)
  );

  pit_prescaler #(.PRE_W(PW)) u_pre (
    .clk(clk), .rst(rst), .run(en), .clear(restart), .sel(pre), .tick(tick)
  );

  pit_counter #(.CNT_W(CW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .restart(restart),
    .force_ld(force_ld), .force_val(bus_wdata[CW-1:0]), .limit(limit),
    .count(count), .pending(pending), .expire(expire)
  );
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          irq,
  input logic          flag,
  input logic          pie,
  input logic          en,
  input logic          tick,
  input logic          pending,
  input logic          expire,
  input logic          force_ld,
  input logic          restart,
  input logic          mod_wr,
  input logic          w1c_wr,
  input logic [CW-1:0] count,
  input logic [CW-1:0] limit
);
  AST_IRQ_IS_FLAG_AND_PIE: assert property (@(posedge clk) disable iff (rst)
    irq == (flag && pie)); // R7
  AST_MOD_WR_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (mod_wr && !expire) |=> !flag); // R8
  AST_W1C_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (w1c_wr && !expire) |=> !flag); // R6
  AST_EXPIRE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    expire |=> flag); // R6
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en && !force_ld) |=> $stable(count)); // R11
  AST_RELOAD_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (expire && !force_ld && !restart) |=> count == $past(limit)); // R4
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (tick && !pending && count != '0 && !force_ld) |=> count == $past(count) - 1'b1); // R3
endmodule

bind pit_timer pit_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .flag(flag), .pie(pie), .en(en),
  .tick(tick), .pending(pending), .expire(expire), .force_ld(force_ld),
  .restart(restart),
  .mod_wr(bus_we && bus_addr == 3'd2),
  .w1c_wr(bus_we && bus_addr == 3'd0 && bus_wdata[2]),
  .count(count), .limit(limit)
);

// File: tb/sim_pit_timer.sv
module sim_pit_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int t0     = 0;
  logic [15:0] rv;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pit_timer u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic go(input int m);
    while (cyc < t0 + m) @(negedge clk);
  endtask

  task automatic mark();
    t0 = cyc;
  endtask

  task automatic t_reset();
    rd(3'd0, rv); chk("R1 ctrl", rv, 16'h0000);
    rd(3'd2, rv); chk("R1 mod", rv, 16'h0000);
    rd(3'd4, rv); chk("R1 cnt", rv, 16'h0000);
    chk("R1 irq", 16'(irq), 16'h0);
  endtask

  task automatic t_regmap();
    wr(3'd2, 16'h1234);
    rd(3'd2, rv); chk("R2 mod readback", rv, 16'h1234);
    wr(3'd4, 16'hBEEF);
    rd(3'd4, rv); chk("R2 cnt write ignored", rv, 16'h0000);
  endtask

  task automatic t_reload();
    wr(3'd2, 16'd5);
    wr(3'd0, 16'h020B); mark();
    go(12);  rd(3'd4, rv); chk("R12 first load", rv, 16'd5);
    go(20);  rd(3'd4, rv); chk("R3 step P=2", rv, 16'd4);
    go(52);  rd(3'd4, rv); chk("R3 reach zero", rv, 16'd0);
    go(60);  rd(3'd4, rv); chk("R4 reload modulus", rv, 16'd5);
    go(62);  rd(3'd0, rv); chk("R6 flag set", rv, 16'h020F);
    chk("R7 irq high", 16'(irq), 16'h1);
    go(66);  wr(3'd0, 16'h020F);
    go(68);  rd(3'd0, rv); chk("R6 w1c", rv, 16'h020B);
    chk("R7 irq low", 16'(irq), 16'h0);
    go(76);  rd(3'd4, rv); chk("R10 w1c no restart", rv, 16'd3);
    go(78);  wr(3'd0, 16'h0203);
    go(84);  rd(3'd4, rv); chk("R10 pie off no restart", rv, 16'd2);
    go(108); rd(3'd0, rv); chk("R6 flag with pie off", rv, 16'h0207);
    chk("R7 irq masked", 16'(irq), 16'h0);
    go(110); wr(3'd0, 16'h020B);
    go(112); chk("R7 irq on enable", 16'(irq), 16'h1);
    rd(3'd0, rv); chk("R6 write zero keeps", rv, 16'h020F);
    go(114); wr(3'd2, 16'd3);
    go(116); rd(3'd0, rv); chk("R8 mod write clears", rv, 16'h020B);
    chk("R8 irq low", 16'(irq), 16'h0);
    go(124); rd(3'd4, rv); chk("R9 no overwrite", rv, 16'd3);
    go(156); rd(3'd4, rv); chk("R9 new modulus at reload", rv, 16'd3);
  endtask

  task automatic t_free();
    wr(3'd0, 16'h0015); mark();
    go(5);  rd(3'd4, rv); chk("R5 load ffff", rv, 16'hFFFE);
    go(8);  wr(3'd2, 16'h0010);
    go(9);  rd(3'd4, rv); chk("R9 overwrite load", rv, 16'h0010);
    go(13); rd(3'd4, rv); chk("R3 step P=0", rv, 16'h000E);
    go(43); rd(3'd4, rv); chk("R5 free-run reload", rv, 16'hFFFF);
    go(45); rd(3'd0, rv); chk("R6 flag free-run", rv, 16'h0015);
    chk("R7 irq masked", 16'(irq), 16'h0);
    go(47); wr(3'd0, 16'h0010);
    go(60); rd(3'd4, rv); chk("R11 hold disabled", rv, 16'hFFFD);
    go(62); rd(3'd0, rv); chk("R6 flag kept", rv, 16'h0014);
  endtask

  task automatic t_enable();
    wr(3'd0, 16'h0311); mark();
    go(10); rd(3'd4, rv); chk("R12 not yet loaded", rv, 16'hFFFD);
    go(18); rd(3'd4, rv); chk("R12 load on first tick", rv, 16'hFFFF);
    go(34); rd(3'd4, rv); chk("R3 step P=3", rv, 16'hFFFE);
    go(36); wr(3'd4, 16'h1234);
    go(40); rd(3'd4, rv); chk("R2 cnt write ignored running", rv, 16'hFFFE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_reload();
    t_free();
    t_enable();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule